// File: doc/BRIEF.md
# I2C Channel Interrupt Collector

This block holds the interrupt side of a bank of I2C channels behind a single register window. Each channel has a small group of registers: a function-control word, two timing words, a 15-bit interrupt-enable word and a 15-bit cause word. The channel transfer engines sit outside the block. They report events by pulsing cause bits and report whether a receive command is still outstanding. The block keeps a global summary word with one bit per channel and drives one registered interrupt line, which is the OR of that summary.

Software reads and writes the block through a simple request port. A request is a valid strobe, a write flag, a 12-bit byte address and 32-bit write data. Read data comes back one cycle after the request, with a valid flag. The address space has a global window at the bottom. Seven channel windows follow it, then a hole of four windows, then the remaining seven channel windows. Any offset that is not decoded reads as all ones.

A channel's cause word is not a plain sticky register. When causes are raised, the whole word is filtered through the enable word that is current at that moment. When software clears a pending receive-done cause while the engine still has a receive command outstanding, the block tells the engine to fetch the next byte.

Top module: `i2c_irq_hub`

## Requirements
- R1: After reset, every control, timing, enable and cause register reads 0, the global summary reads 0, the interrupt output is 0 and no receive-continue pulse is present.
- R2: In a cycle where any cause bit of a channel is pulsed, that channel's cause word becomes (old word after any same-cycle clear, OR the pulsed bits) AND its enable word as it stood before that cycle's write. As a result, bit 15 (slave inactivity timeout) and any cause that is not enabled are never held, and held causes whose enable has since been removed are dropped.
- R3: When a raise leaves a channel's cause word nonzero, summary bit i (bit position = channel index) reads 1 from the next cycle on.
- R4: A write to cause-word offset 0x10 clears exactly the bits that are 1 in write-data bits 14:0. Write-data bits 31:15 have no effect.
- R5: A summary bit clears only when a write to that channel's cause word leaves the word at zero. A clear that leaves other causes pending keeps the bit set.
- R6: If a cause write clears RX_DONE (bit 2) while bit 2 was set and that channel's rx_pending is high, rx_next for that channel pulses for exactly one cycle, in the cycle after the write. In every other case rx_next stays low.
- R7: Channel i (0 to 13) has its window at byte base (i+1)*0x40 for i < 7 and at (i+5)*0x40 otherwise. Inside a window the offsets are: control 0x00, timing-1 0x04, timing-2 0x08, enable 0x0C, cause 0x10.
- R8: A read returns data with bus_rvalid one cycle later. Reads of the global window other than offset 0x000, of the hole 0x200 to 0x2FF, of addresses at 0x4C0 and above, and of window offsets beyond 0x10 return 0xFFFFFFFF.
- R9: Writes to the global summary at offset 0x000 are ignored.
- R10: Stored values keep only the writable bits. Control keeps mask 0x0071C3FF, timing-1 keeps 0x0FFFFF0F, timing-2 keeps 0x7 and enable keeps 0x7FFF.
- R11: When a clear and a raise hit the same channel in the same cycle, the clear is applied first and the raise second.
- R12: irq equals the OR of the summary bits as they stood one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Register request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the request |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the request |
| bus_rvalid | output | 1 | Read data valid |
| cause_set | input | 224 | Cause pulses, 16 bits per channel, channel i at bits [16i+15:16i] |
| rx_pending | input | 14 | Per-channel receive command outstanding |
| rx_next | output | 14 | Per-channel receive-continue pulse |
| irq | output | 1 | Registered aggregate interrupt |

## Verification
The bench targets the corner cases where this block departs from a plain sticky status register. It checks that a new raise drops a held cause whose enable was removed in the meantime; a design that masked only the incoming bits would keep that cause. It checks that a partial clear keeps the summary bit and the interrupt high; a design that cleared the summary on any write would drop the interrupt early. It checks that a clear and a raise on the same channel in the same cycle apply the clear first, so that a freshly raised cause is not lost. It also checks that rx_next pulses only when RX_DONE was actually set and a receive is outstanding; a design that decoded only the written bit would request bytes that nobody is waiting for. Finally, it checks that the four-window hole and the windows past the last channel read as all ones; an off-by-one in window placement shows up as channel data at the wrong address.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;

    localparam int DATA_W   = 32;
    localparam int CAUSE_W  = 16;   // cause pulses as delivered by an engine
    localparam int EN_W     = 15;   // bits held in enable and cause words
    localparam int RXDONE_B = 2;    // receive-done cause position

    localparam logic [DATA_W-1:0] CTRL_KEEP = 32'h0071_C3FF;
    localparam logic [DATA_W-1:0] TIM1_KEEP = 32'h0FFF_FF0F;
    localparam logic [DATA_W-1:0] TIM2_KEEP = 32'h0000_0007;

    typedef enum logic [2:0] {
        RSEL_NONE,
        RSEL_CTRL,
        RSEL_TIM1,
        RSEL_TIM2,
        RSEL_IEN,
        RSEL_CAUSE
    } rsel_e;

    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] tim1;
        logic [2:0]        tim2;
        logic [EN_W-1:0]   ien;
        logic [EN_W-1:0]   cause;
        logic              rx_next;
    } chan_regs_t;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
    } rd_path_t;

endpackage

// File: rtl/i2c_irq_decode.sv
module i2c_irq_decode
    import i2c_irq_pkg::*;
#(
    parameter int NCH      = 14,
    parameter int GAP_IDX  = 7,
    parameter int GAP_WINS = 4,
    parameter int ADDR_W   = 12,
    parameter int WIN_LSB  = 6
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NCH-1:0]    ch_hit,
    output logic              glob_hit,
    output rsel_e             sel
);
    localparam int WIN_W  = ADDR_W - WIN_LSB;
    localparam int WORD_W = WIN_LSB - 2;

    logic [WIN_W-1:0]  win;
    logic [WORD_W-1:0] word;

    assign win  = addr[ADDR_W-1:WIN_LSB];
    assign word = addr[WIN_LSB-1:2];

    for (genvar i = 0; i < NCH; i++) begin : g_win
        localparam int WIN_NUM = (i < GAP_IDX) ? (i + 1) : (i + 1 + GAP_WINS);
        assign ch_hit[i] = (win == WIN_W'(WIN_NUM));
    end

    assign glob_hit = (win == '0) && (word == '0);

    always_comb begin
        unique case (word)
            WORD_W'(0): sel = RSEL_CTRL;
            WORD_W'(1): sel = RSEL_TIM1;
            WORD_W'(2): sel = RSEL_TIM2;
            WORD_W'(3): sel = RSEL_IEN;
            WORD_W'(4): sel = RSEL_CAUSE;
            default:    sel = RSEL_NONE;
        endcase
    end

endmodule

// File: rtl/i2c_irq_chan.sv
module i2c_irq_chan
    import i2c_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  rsel_e              sel,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [CAUSE_W-1:0] cause_set,
    input  logic               rx_pend,
    output logic [DATA_W-1:0]  rd_val,
    output logic               glob_set,
    output logic               glob_clr,
    output logic               rx_next
);
    chan_regs_t r_d, r_q;

    logic            wr_cause;
    logic            raise;
    logic [EN_W-1:0] w1c;
    logic [EN_W-1:0] kept;
    logic [EN_W-1:0] cause_nx;

    always_comb begin
        r_d      = r_q;
        wr_cause = wr_en && (sel == RSEL_CAUSE);
        w1c      = wr_cause ? wdata[EN_W-1:0] : '0;
        raise    = |cause_set;

        // clear first, then merge the raised causes through the old enable
        kept     = r_q.cause & ~w1c;
        cause_nx = raise ? ((kept | cause_set[EN_W-1:0]) & r_q.ien) : kept;
        r_d.cause = cause_nx;

        glob_set = raise && (cause_nx != '0);
        glob_clr = wr_cause && (cause_nx == '0) && !glob_set;

        r_d.rx_next = wr_cause && r_q.cause[RXDONE_B] && w1c[RXDONE_B] && rx_pend;

        if (wr_en) begin
            unique case (sel)
                RSEL_CTRL: r_d.ctrl = wdata & CTRL_KEEP;
                RSEL_TIM1: r_d.tim1 = wdata & TIM1_KEEP;
                RSEL_TIM2: r_d.tim2 = wdata[2:0];
                RSEL_IEN:  r_d.ien  = wdata[EN_W-1:0];
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        unique case (sel)
            RSEL_CTRL:  rd_val = r_q.ctrl;
            RSEL_TIM1:  rd_val = r_q.tim1;
            RSEL_TIM2:  rd_val = {{(DATA_W-3){1'b0}}, r_q.tim2};
            RSEL_IEN:   rd_val = {{(DATA_W-EN_W){1'b0}}, r_q.ien};
            RSEL_CAUSE: rd_val = {{(DATA_W-EN_W){1'b0}}, r_q.cause};
            default:    rd_val = '1;
        endcase
    end

    assign rx_next = r_q.rx_next;

    AST_RAISE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (|cause_set) |=> ((r_q.cause & ~$past(r_q.ien)) == '0)); // R2

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == RSEL_CAUSE && !(|cause_set))
            |=> ((r_q.cause & $past(wdata[EN_W-1:0])) == '0)); // R4

    AST_RXNEXT_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        rx_next |-> $past(rx_pend)); // R6

    AST_RXNEXT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_next |=> !rx_next); // R6

endmodule

// File: rtl/i2c_irq_agg.sv
module i2c_irq_agg #(
    parameter int NCH = 14
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] glob_set,
    input  logic [NCH-1:0] glob_clr,
    output logic [NCH-1:0] glob,
    output logic           irq
);
    typedef struct packed {
        logic [NCH-1:0] summ;
        logic           irq;
    } agg_t;

    agg_t a_d, a_q;

    always_comb begin
        a_d      = a_q;
        a_d.summ = (a_q.summ | glob_set) & ~(glob_clr & ~glob_set);
        a_d.irq  = |a_q.summ;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    assign glob = a_q.summ;
    assign irq  = a_q.irq;

    AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (|glob_set) |=> ((glob & $past(glob_set)) == $past(glob_set))); // R3

    AST_CLR_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~glob & $past(glob) & ~$past(glob_clr)) == '0)); // R5

    AST_IRQ_IS_OR: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == (|$past(glob)))); // R12

endmodule

// File: rtl/i2c_irq_hub.sv
module i2c_irq_hub
    import i2c_irq_pkg::*;
#(
    parameter int NCH      = 14,
    parameter int GAP_IDX  = 7,
    parameter int GAP_WINS = 4,
    parameter int ADDR_W   = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_valid,
    input  logic                   bus_write,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    output logic                   bus_rvalid,
    input  logic [NCH*CAUSE_W-1:0] cause_set,
    input  logic [NCH-1:0]         rx_pending,
    output logic [NCH-1:0]         rx_next,
    output logic                   irq
);
    logic [NCH-1:0]             ch_hit;
    logic                       glob_hit;
    rsel_e                      sel;
    logic [NCH-1:0]             g_set;
    logic [NCH-1:0]             g_clr;
    logic [NCH-1:0]             glob;
    logic [NCH-1:0][DATA_W-1:0] chan_rd;
    logic [DATA_W-1:0]          rd_mux;
    rd_path_t                   p_d, p_q;

    i2c_irq_decode #(
        .NCH(NCH), .GAP_IDX(GAP_IDX), .GAP_WINS(GAP_WINS), .ADDR_W(ADDR_W), .WIN_LSB(6)
    ) u_dec (
        .addr(bus_addr), .ch_hit(ch_hit), .glob_hit(glob_hit), .sel(sel)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        i2c_irq_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (bus_valid && bus_write && ch_hit[i]),
            .sel      (sel),
            .wdata    (bus_wdata),
            .cause_set(cause_set[i*CAUSE_W +: CAUSE_W]),
            .rx_pend  (rx_pending[i]),
            .rd_val   (chan_rd[i]),
            .glob_set (g_set[i]),
            .glob_clr (g_clr[i]),
            .rx_next  (rx_next[i])
        );
    end

    i2c_irq_agg #(.NCH(NCH)) u_agg (
        .clk(clk), .rst_n(rst_n), .glob_set(g_set), .glob_clr(g_clr),
        .glob(glob), .irq(irq)
    );

    always_comb begin
        rd_mux = '1;
        if (glob_hit) begin
            rd_mux = {{(DATA_W-NCH){1'b0}}, glob};
        end else if ((|ch_hit) && (sel != RSEL_NONE)) begin
            rd_mux = '0;
            for (int i = 0; i < NCH; i++) begin
                if (ch_hit[i]) rd_mux = rd_mux | chan_rd[i];
            end
        end
        p_d        = p_q;
        p_d.rvalid = bus_valid && !bus_write;
        if (bus_valid && !bus_write) p_d.rdata = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign bus_rdata  = p_q.rdata;
    assign bus_rvalid = p_q.rvalid;

    AST_UNMAPPED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_write && !glob_hit && !(|ch_hit)) |=> (bus_rdata == '1)); // R8

    AST_RVALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (bus_rvalid == $past(bus_valid && !bus_write))); // R8

    AST_CHAN_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_hit) && !(glob_hit && (|ch_hit))); // R7

endmodule

// File: tb/i2c_irq_hub_tb_top.sv
module i2c_irq_hub_tb_top;
    localparam int NCH = 14;
    localparam int CW  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_valid = 1'b0;
    logic              bus_write = 1'b0;
    logic [11:0]       bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              bus_rvalid;
    logic [NCH*CW-1:0] cause_in = '0;
    logic [NCH-1:0]    rxp_in = '0;
    logic [NCH-1:0]    rx_next;
    logic              irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // behavioural model state
    logic [31:0] m_ctl [NCH];
    logic [31:0] m_t1  [NCH];
    logic [31:0] m_t2  [NCH];
    logic [31:0] m_en  [NCH];
    logic [31:0] m_st  [NCH];
    bit          m_gl  [NCH];
    bit          m_irq;
    string       cur_tag = "R8";

    always #5 clk = ~clk;

    i2c_irq_hub dut_i (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .cause_set(cause_in), .rx_pending(rxp_in),
        .rx_next(rx_next), .irq(irq)
    );

    function automatic int unsigned base_of(int i);
        return (i < 7) ? (i + 1) * 64 : (i + 5) * 64;
    endfunction

    function automatic void locate(input int unsigned a, output int ch, output int off);
        ch = -1;
        off = 0;
        for (int i = 0; i < NCH; i++) begin
            if (a >= base_of(i) && a < base_of(i) + 64) begin
                ch = i;
                off = int'(a - base_of(i)) & ~3;
            end
        end
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic cycle();
        int ch, off;
        logic [31:0] exp_rd;
        logic [31:0] nst [NCH];
        bit ngl [NCH];
        bit nrx [NCH];
        bit exp_rv;
        bit nirq;
        locate(int'(bus_addr), ch, off);
        exp_rv = bus_valid && !bus_write;
        exp_rd = 32'hFFFF_FFFF;
        if ((bus_addr & 12'hFFC) == 12'h000) begin
            exp_rd = 0;
            for (int i = 0; i < NCH; i++) exp_rd[i] = m_gl[i];
        end else if (ch >= 0) begin
            case (off)
                0: exp_rd = m_ctl[ch];
                4: exp_rd = m_t1[ch];
                8: exp_rd = m_t2[ch];
                12: exp_rd = m_en[ch];
                16: exp_rd = m_st[ch];
                default: exp_rd = 32'hFFFF_FFFF;
            endcase
        end
        nirq = 1'b0;
        for (int i = 0; i < NCH; i++) nirq = nirq | m_gl[i];
        for (int i = 0; i < NCH; i++) begin
            logic [31:0] w1c, kept, c;
            bit wst, up;
            wst = bus_valid && bus_write && ch == i && off == 16;
            w1c = wst ? (bus_wdata & 32'h7FFF) : 32'h0;
            kept = m_st[i] & ~w1c;
            c = 32'(cause_in[i*CW +: CW]);
            up = (c != 0);
            nst[i] = up ? ((kept | c) & m_en[i]) : kept;
            ngl[i] = (up && nst[i] != 0) ? 1'b1 : ((wst && nst[i] == 0) ? 1'b0 : m_gl[i]);
            nrx[i] = wst && m_st[i][2] && w1c[2] && rxp_in[i];
        end
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < NCH; i++) begin
            m_st[i] = nst[i];
            m_gl[i] = ngl[i];
            if (bus_valid && bus_write && ch == i) begin
                case (off)
                    0: m_ctl[i] = bus_wdata & 32'h0071C3FF;
                    4: m_t1[i] = bus_wdata & 32'h0FFFFF0F;
                    8: m_t2[i] = bus_wdata & 32'h7;
                    12: m_en[i] = bus_wdata & 32'h7FFF;
                    default: ;
                endcase
            end
            check("R6", 32'(rx_next[i]), 32'(nrx[i]), $sformatf("rx_next[%0d]", i));
        end
        m_irq = nirq;
        check("R12", 32'(irq), 32'(m_irq), "irq");
        check(cur_tag, 32'(bus_rvalid), 32'(exp_rv), "rvalid");
        if (exp_rv) check(cur_tag, bus_rdata, exp_rd, $sformatf("rdata @%h", bus_addr));
    endtask

    task automatic wr(int unsigned a, logic [31:0] d);
        bus_valid = 1; bus_write = 1; bus_addr = 12'(a); bus_wdata = d;
        cycle();
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic rd(int unsigned a, string tag);
        bus_valid = 1; bus_write = 0; bus_addr = 12'(a); cur_tag = tag;
        cycle();
        bus_valid = 0; cur_tag = "R8";
    endtask

    task automatic raise(int ch, logic [15:0] bits);
        cause_in[ch*CW +: CW] = bits;
        cycle();
        cause_in = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NCH; i++) begin
            m_ctl[i] = 0; m_t1[i] = 0; m_t2[i] = 0; m_en[i] = 0; m_st[i] = 0; m_gl[i] = 0;
        end
        m_irq = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1", 32'(irq), 32'h0, "irq after reset");
        rd(32'h000, "R1");
        rd(base_of(0) + 16, "R1");
        rd(base_of(13) + 12, "R1");
        rd(base_of(5) + 0, "R1");
        // R10 write masks
        wr(base_of(2) + 0, 32'hFFFF_FFFF);  rd(base_of(2) + 0, "R10");
        wr(base_of(2) + 4, 32'hFFFF_FFFF);  rd(base_of(2) + 4, "R10");
        wr(base_of(2) + 8, 32'hFFFF_FFFF);  rd(base_of(2) + 8, "R10");
        wr(base_of(2) + 12, 32'hFFFF_FFFF); rd(base_of(2) + 12, "R10");
        // R2 raise filtered by enable, bit 15 dropped
        wr(base_of(0) + 12, 32'h0000_8005);
        raise(0, 16'h8007);
        rd(base_of(0) + 16, "R2");
        rd(32'h000, "R3");
        cycle();
        // R4 partial clear, upper bits ignored; R5 summary stays
        wr(base_of(0) + 16, 32'hFFFF_8001);
        rd(base_of(0) + 16, "R4");
        rd(32'h000, "R5");
        // R6 clear RX_DONE with receive pending
        rxp_in[0] = 1'b1;
        wr(base_of(0) + 16, 32'h4);
        rd(base_of(0) + 16, "R4");
        rd(32'h000, "R5");
        // R6 clear when RX_DONE is not set: no pulse
        wr(base_of(0) + 16, 32'h4);
        rxp_in[0] = 1'b0;
        // R6 RX_DONE set but no receive pending: no pulse
        raise(0, 16'h0004);
        wr(base_of(0) + 16, 32'h4);
        // R2/R3 raise with all causes disabled
        raise(4, 16'h7FFF);
        rd(base_of(4) + 16, "R2");
        rd(32'h000, "R3");
        // R2 held cause dropped once its enable is removed and a raise occurs
        wr(base_of(1) + 12, 32'h7FFF);
        raise(1, 16'h0005);
        wr(base_of(1) + 12, 32'h0004);
        rd(base_of(1) + 16, "R2");
        raise(1, 16'h0004);
        rd(base_of(1) + 16, "R2");
        // R11 same-cycle clear and raise
        wr(base_of(1) + 12, 32'h7FFF);
        cause_in[1*CW +: CW] = 16'h0004;
        bus_valid = 1; bus_write = 1; bus_addr = 12'(base_of(1) + 16); bus_wdata = 32'h4;
        cycle();
        bus_valid = 0; bus_write = 0; cause_in = '0;
        rd(base_of(1) + 16, "R11");
        rd(32'h000, "R11");
        wr(base_of(1) + 16, 32'h7FFF);
        rd(32'h000, "R5");
        // R7 placement of every window
        for (int i = 0; i < NCH; i++) wr(base_of(i) + 12, 32'(i * 3 + 1));
        for (int i = 0; i < NCH; i++) rd(base_of(i) + 12, "R7");
        // R8 unmapped reads
        rd(32'h004, "R8");
        rd(32'h03C, "R8");
        rd(32'h200, "R8");
        rd(32'h2FC, "R8");
        rd(32'h4C0, "R8");
        rd(32'hFFC, "R8");
        rd(base_of(3) + 20, "R8");
        rd(base_of(10) + 60, "R8");
        // R9 summary writes ignored; R12 two channels
        wr(base_of(3) + 12, 32'h7FFF);
        wr(base_of(10) + 12, 32'h7FFF);
        cause_in[3*CW +: CW] = 16'h0010;
        cause_in[10*CW +: CW] = 16'h0020;
        cycle();
        cause_in = '0;
        wr(32'h000, 32'h0000_0000);
        rd(32'h000, "R9");
        wr(32'h000, 32'hFFFF_FFFF);
        rd(32'h000, "R9");
        wr(base_of(3) + 16, 32'h10);
        cycle();
        check("R12", 32'(irq), 32'h1, "irq with one channel left");
        wr(base_of(10) + 16, 32'h20);
        cycle();
        cycle();
        check("R12", 32'(irq), 32'h0, "irq after all cleared");
        rd(32'h000, "R5");
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule